// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a small synchronous up-counter with a parallel preset, a synchronous clear and two separate count-enable inputs. Every change of the stored count happens on the rising clock edge. Three controls set what happens at that edge. An active-low clear has the highest priority. An active-low load comes next and copies the preset bus into the count. Counting comes last, and it needs both enables high.

The carry output is combinational. It is high only when the count is all ones and the "chain" enable is high. The other enable has no effect on it. Wiring each stage's carry into the chain enable of the next stage builds a wider counter that runs from one shared clock. The count width is a parameter with a default of 4 bits.

Top module: `pcnt_top`

## Requirements
- R1: While `rst_n` is low, the next rising edge sets `q` to 0. This holds whatever `load_n`, `en_p`, `en_t` and `din` are, and clear has priority over load and count.
- R2: While `rst_n` is high and `load_n` is low, the next rising edge sets `q` to `din`, with bit i of `din` going to bit i of `q` (bit 0 is the LSB). Both enables are ignored.
- R3: While `rst_n` and `load_n` are high and both `en_p` and `en_t` are high, the next rising edge increments `q` by one in plain binary.
- R4: While `rst_n` and `load_n` are high and either `en_p` or `en_t` is low, `q` holds its value across the edge.
- R5: When counting from all ones (15 for 4 bits), `q` goes to 0 on that same edge, with no extra cycle.
- R6: `carry_o` is 1 exactly when `en_t` is 1 and every bit of `q` is 1. `en_p` has no effect on it.
- R7: `carry_o` follows a change of `en_t` within the same clock phase, with no clock edge in between.
- R8: When stages are chained (stage k's `en_t` takes stage k-1's `carry_o`, the first stage's `en_t` is high, and all `en_p` inputs are shared), the combined count steps as one binary counter of the total width and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset, active low |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Preset data, bit i goes to q bit i |
| q | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
The bench first loads every starting value. It then applies every combination of clear, load and the two enables, and predicts the next count by arithmetic. This catches a wrong priority, such as load beating clear or enables gating the preset. It also catches a count that moves when only one enable is high. Before each edge the bench checks the carry for every value and both enables. A carry that used `en_p`, or one that fired below all ones, would be reported. The bench checks the wrap from 15 to 0 directly, and it toggles `en_t` mid-cycle to show the carry is combinational. Finally, a chain of parameterised stages is checked against an integer counter through a full wrap. A carry that was registered or late would make the upper stages lag by one count.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  // Action chosen for the next rising edge, in priority order
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } pcnt_act_e;

  // Binary increment that wraps at 2**w
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned w);
    int unsigned span;
    span = 32'd1 << w;
    return (v + 32'd1) % span;
  endfunction

  // Largest value a w-bit counter can hold
  function automatic int unsigned top_value(int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic      rst_n,
  input  logic      load_n,
  input  logic      en_p,
  input  logic      en_t,
  output pcnt_act_e act,
  output logic      do_clear,
  output logic      do_load,
  output logic      do_count,
  output logic      do_hold
);

  // Fixed priority: clear, then load, then count, else hold
  always_comb begin
    if (!rst_n)               act = ACT_CLEAR;
    else if (!load_n)         act = ACT_LOAD;
    else if (en_p && en_t)    act = ACT_COUNT;
    else                      act = ACT_HOLD;
  end

  assign do_clear = (act == ACT_CLEAR);
  assign do_load  = (act == ACT_LOAD);
  assign do_count = (act == ACT_COUNT);
  assign do_hold  = (act == ACT_HOLD);

endmodule

// File: rtl/pcnt_bits.sv
module pcnt_bits
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  pcnt_act_e        act,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] lower_full
);

  logic [WIDTH-1:0] q_r;

  // lower_full[i]: every bit below i is one, so bit i toggles on count
  assign lower_full[0] = 1'b1;
  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign lower_full[i] = lower_full[i-1] & q_r[i-1];
  end

  // One toggle-enable flip-flop per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      unique case (act)
        ACT_CLEAR: q_r[i] <= 1'b0;
        ACT_LOAD:  q_r[i] <= din[i];
        ACT_COUNT: q_r[i] <= q_r[i] ^ lower_full[i];
        default:   q_r[i] <= q_r[i];
      endcase
    end
  end

  assign q = q_r;

endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic             en_t,
  input  logic [WIDTH-1:0] q,
  output logic             at_top,
  output logic             carry
);

  assign at_top = &q;
  assign carry  = en_t & at_top;

endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_o
);

  localparam int unsigned TOP = top_value(WIDTH);

  pcnt_act_e        act;
  logic             do_clear, do_load, do_count, do_hold;
  logic [WIDTH-1:0] lower_full;
  logic             at_top;

  pcnt_ctrl u_ctrl (
    .rst_n   (rst_n),
    .load_n  (load_n),
    .en_p    (en_p),
    .en_t    (en_t),
    .act     (act),
    .do_clear(do_clear),
    .do_load (do_load),
    .do_count(do_count),
    .do_hold (do_hold)
  );

  pcnt_bits #(.WIDTH(WIDTH)) u_bits (
    .clk       (clk),
    .act       (act),
    .din       (din),
    .q         (q),
    .lower_full(lower_full)
  );

  pcnt_carry #(.WIDTH(WIDTH)) u_carry (
    .en_t  (en_t),
    .q     (q),
    .at_top(at_top),
    .carry (carry_o)
  );

  // R1: exactly one action per edge; clear wins and zeroes the count
  p_one_action_r1: assert property (@(posedge clk)
    $countones({do_clear, do_load, do_count, do_hold}) == 1);
  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (q == '0));

  // R2: preset copies the data bus whatever the enables are
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (q == $past(din)));

  // R3, R5: increment with wrap
  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_p && en_t) |=>
      (int'(q) == int'(wrap_inc(int'($past(q)), WIDTH))));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_p && en_t && (int'(q) == int'(TOP))) |=> (q == '0));

  // R4: no change without both enables
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R6: carry only at the top value with the chain enable set
  p_carry_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (int'(q) == int'(TOP)) && en_t);
  p_carry_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_t && at_top) |-> carry_o);

endmodule

// File: tb/pcnt_top_tb_top.sv
`timescale 1ns/1ps
module pcnt_top_tb_top;

  localparam int W    = 4;
  localparam int NST  = 3;
  localparam int CW   = W * NST;
  localparam int MODV = 1 << W;
  localparam int CMOD = 1 << CW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // single stage under test
  logic         rst_n, load_n, en_p, en_t;
  logic [W-1:0] din, q;
  logic         carry_o;

  pcnt_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q), .carry_o(carry_o)
  );

  // cascade of NST stages
  logic         c_rst_n, c_ce;
  logic [W-1:0] cq [NST];
  logic         ccar [NST];

  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic et;
    if (k == 0) begin : g_first
      assign et = 1'b1;
    end else begin : g_next
      assign et = ccar[k-1];
    end
    pcnt_top #(.WIDTH(W)) u_stage (
      .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .en_p(c_ce), .en_t(et),
      .din('0), .q(cq[k]), .carry_o(ccar[k])
    );
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cascade_val();
    int v = 0;
    for (int k = 0; k < NST; k++) v = v | (int'(cq[k]) << (W * k));
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int exp, ref_v;
    rst_n = 0; load_n = 0; en_p = 1; en_t = 1; din = 4'd5;
    c_rst_n = 0; c_ce = 1;

    // R1: clear beats load and count
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", int'(q), 0);

    // R1..R6: every start value against every control combination
    for (int s = 0; s < MODV; s++) begin
      for (int c = 0; c < 16; c++) begin
        int dv;
        string tag;
        dv = (s * 7 + 3 + c) % MODV;
        rst_n = 1; load_n = 0; en_p = 0; en_t = 0; din = W'(s);
        @(negedge clk);
        chk("R2 preload", int'(q), s);
        rst_n = c[3]; load_n = c[2]; en_p = c[1]; en_t = c[0]; din = W'(dv);
        #1;
        chk("R6 carry", int'(carry_o), (c[0] && s == MODV - 1) ? 1 : 0);
        if (!c[3])            begin exp = 0;  tag = "R1 clear"; end
        else if (!c[2])       begin exp = dv; tag = "R2 load"; end
        else if (c[1] && c[0]) begin
          exp = (s + 1) % MODV;
          tag = (s == MODV - 1) ? "R5 wrap" : "R3 count";
        end
        else                  begin exp = s;  tag = "R4 hold"; end
        @(negedge clk);
        chk(tag, int'(q), exp);
      end
    end

    // R7: carry follows en_t mid-cycle at the top value
    rst_n = 1; load_n = 0; din = 4'd15; en_p = 0; en_t = 0;
    @(negedge clk);
    load_n = 1;
    #1 chk("R7 carry low", int'(carry_o), 0);
    #2 en_t = 1;
    #1 chk("R7 carry rises", int'(carry_o), 1);
    #2 en_t = 0;
    #1 chk("R7 carry falls", int'(carry_o), 0);

    // R3 R5 R4: clear, preset 12, count to 2, then inhibit
    @(negedge clk);
    rst_n = 0; load_n = 1; en_p = 0; en_t = 0;
    @(negedge clk);
    chk("R1 seq clear", int'(q), 0);
    rst_n = 1; load_n = 0; din = 4'd12;
    @(negedge clk);
    chk("R2 seq preset", int'(q), 12);
    load_n = 1; en_p = 1; en_t = 1;
    exp = 12;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      exp = (exp + 1) % MODV;
      chk((exp == 0) ? "R5 seq wrap" : "R3 seq count", int'(q), exp);
    end
    en_p = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 seq inhibit", int'(q), 2);
    end

    // R8: cascade against an integer reference through a full wrap
    c_rst_n = 0;
    @(negedge clk);
    c_rst_n = 1;
    ref_v = 0;
    chk("R8 cascade reset", cascade_val(), 0);
    for (int n = 0; n < CMOD + 600; n++) begin
      c_ce = ((n % 11) != 5);
      @(negedge clk);
      if (c_ce) ref_v = (ref_v + 1) % CMOD;
      chk("R8 cascade", cascade_val(), ref_v);
    end

    finish_run();
  end

endmodule